// File: doc/BRIEF.md
# Dual-Compare Interval Timer

This block is one timer channel. It has a 16-bit count register, two limit registers and a control register. A free-running divider services the channel once every four clocks. On each service, an enabled channel either increments its count or, when the count has reached one below the active limit, wraps the count to zero and ends the current phase.

In single-limit mode only limit A is used. The output pin stays high and drops low for one service interval at each wrap. In dual-limit mode the channel alternates between an A phase and a B phase, and the output pin shows which limit is active. With the loop bit set the phases repeat and form a periodic waveform. With the loop bit clear the channel stops itself at the end of the sequence. The run bit can only be changed by a control write that also sets the key bit. The timer input pin can be selected as an extra gate on counting.

Top module: `dual_cmp_timer`

## Requirements
- R1: In dual mode the output is high during the A phase and low during the B phase. For example, 44 clocks after a start with A=10 and B=20, the output is low and the count reads 1.
- R2: When a sequence ends, the output is high. This holds when the loop bit is clear: after a non-looping dual sequence finishes, the output stays high.
- R3: Looping dual mode with A=10 and B=20 repeats every 120 clocks, and the output is high for exactly one third of that period (80 of any 240 consecutive clocks).
- R4: While the channel is not enabled (run bit clear, or the gate is closed), service ticks leave the count register unchanged.
- R5: Register map for writes and reads: address 0 is the count, 1 is limit A, 2 is limit B, 3 is control. Control bits are: bit0 run, bit1 key (write-only, reads 0), bit2 loop, bit3 dual, bit4 gate. A control write changes the run bit only when bit1 is set in that same write. The other control bits are always written.
- R6: With the gate bit set, the channel counts only while the timer input pin is high.
- R7: With the loop bit clear, the run bit clears by itself at the end of the sequence. In single mode this happens at the limit A wrap. In dual mode it happens at the limit B wrap.
- R8: When the count equals the active limit minus one, the next service wraps the count to 0. The largest count value ever seen is the limit minus one.
- R9: An enabled channel is serviced once every 4 clocks. In any run of 4N clocks it receives exactly N services.
- R10: A limit value of 0 acts as 65536. The count then passes through 0xFFFF and wraps to 0.
- R11: In single mode the output is high, except for a low pulse lasting one service interval (4 clocks) at each wrap.
- R12: A control write that sets run from 0 to 1 clears the count to 0 and starts at the A phase.
- R13: After reset the count, limits and control read 0, and the output is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write register address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 2 | Read register address |
| rd_data | output | 16 | Read data (combinational) |
| tmr_in | input | 1 | Timer input pin, used as a counting gate |
| tmr_out | output | 1 | Timer output pin |

## Verification
The count path is driven through a table of limits and wait lengths. Each length is a multiple of four clocks, so that wrap arithmetic, single-count limits and the zero-means-full-range rule can each be told apart from the plain service rate. The output is measured by counting high and low clocks over whole waveform periods. This separates the single-mode wrap pulse, the dual-mode phase indication and the one-third duty cycle, and it shows whether a stopped sequence leaves the pin high. Writes with and without the key bit, together with gate-pin toggling, show whether counting is blocked or allowed by the right condition.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   typedef enum logic [1:0] {
      ADDR_COUNT = 2'd0,
      ADDR_LIM_A = 2'd1,
      ADDR_LIM_B = 2'd2,
      ADDR_CTRL  = 2'd3
   } tmr_addr_e;

   localparam int unsigned BIT_RUN  = 0;
   localparam int unsigned BIT_KEY  = 1;
   localparam int unsigned BIT_LOOP = 2;
   localparam int unsigned BIT_DUAL = 3;
   localparam int unsigned BIT_GATE = 4;

   typedef enum logic {
      PH_A = 1'b0,
      PH_B = 1'b1
   } tmr_phase_e;
endpackage

// File: rtl/tmr_tick.sv
module tmr_tick #(
   parameter int unsigned DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   generate
      if (DIV < 1) begin : g_bad
         $error("tmr_tick: DIV must be at least 1");
      end
      if (DIV == 1) begin : g_every
         assign tick = 1'b1;
      end else begin : g_div
         localparam int unsigned W = $clog2(DIV);
         localparam logic [W-1:0] LAST = W'(DIV - 1);
         logic [W-1:0] div_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)              div_q <= '0;
            else if (div_q == LAST)  div_q <= '0;
            else                     div_q <= div_q + 1'b1;
         end
         assign tick = (div_q == LAST);
      end
   endgenerate
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
   import tmr_pkg::*;
#(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [1:0]       wr_addr,
   input  logic [CNT_W-1:0] wr_data,
   input  logic             seq_done,
   output logic             run,
   output logic             loop_md,
   output logic             dual_md,
   output logic             gate_md,
   output logic             start,
   output logic [CNT_W-1:0] lim_a,
   output logic [CNT_W-1:0] lim_b
);
   logic ctrl_wr, key_wr;

   assign ctrl_wr = wr_en && (wr_addr == ADDR_CTRL);
   assign key_wr  = ctrl_wr && wr_data[BIT_KEY];
   assign start   = key_wr && wr_data[BIT_RUN] && !run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run     <= 1'b0;
         loop_md <= 1'b0;
         dual_md <= 1'b0;
         gate_md <= 1'b0;
      end else begin
         if (ctrl_wr) begin
            loop_md <= wr_data[BIT_LOOP];
            dual_md <= wr_data[BIT_DUAL];
            gate_md <= wr_data[BIT_GATE];
         end
         if (key_wr)        run <= wr_data[BIT_RUN];
         else if (seq_done) run <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lim_a <= '0;
         lim_b <= '0;
      end else if (wr_en) begin
         if (wr_addr == ADDR_LIM_A) lim_a <= wr_data;
         if (wr_addr == ADDR_LIM_B) lim_b <= wr_data;
      end
   end

   AST_RUN_NEEDS_KEY: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr && !wr_data[BIT_KEY] && !seq_done) |=> $stable(run)); // R5
   AST_SELF_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_done && !key_wr) |=> !run); // R7
endmodule

// File: rtl/tmr_core.sv
module tmr_core
   import tmr_pkg::*;
#(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             active,
   input  logic             loop_md,
   input  logic             dual_md,
   input  logic             start,
   input  logic             cnt_wr,
   input  logic [CNT_W-1:0] cnt_wdata,
   input  logic [CNT_W-1:0] lim_a,
   input  logic [CNT_W-1:0] lim_b,
   output logic [CNT_W-1:0] count,
   output logic             pin_out,
   output logic             seq_done
);
   tmr_phase_e       phase;
   logic             pulse;
   logic             in_b;
   logic [CNT_W-1:0] lim_sel, last;
   logic             hit, seq_end;

   assign in_b     = dual_md && (phase == PH_B);
   assign lim_sel  = in_b ? lim_b : lim_a;
   assign last     = lim_sel - CNT_W'(1);
   assign hit      = tick && active && (count == last);
   assign seq_end  = hit && (!dual_md || phase == PH_B);
   assign seq_done = seq_end && !loop_md;
   assign pin_out  = dual_md ? (phase == PH_A) : !pulse;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
         phase <= PH_A;
         pulse <= 1'b0;
      end else if (start) begin
         count <= '0;
         phase <= PH_A;
         pulse <= 1'b0;
      end else begin
         if (cnt_wr)                count <= cnt_wdata;
         else if (tick && active)   count <= hit ? '0 : count + 1'b1;
         if (hit && dual_md)        phase <= (phase == PH_A) ? PH_B : PH_A;
         if (tick)                  pulse <= hit && !dual_md;
      end
   end

   AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!active && !start && !cnt_wr) |=> $stable(count)); // R4
   AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && !start && !cnt_wr) |=> (count == '0)); // R8
endmodule

// File: rtl/dual_cmp_timer.sv
module dual_cmp_timer
   import tmr_pkg::*;
#(
   parameter int unsigned CNT_W    = 16,
   parameter int unsigned TICK_DIV = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [1:0]       wr_addr,
   input  logic [CNT_W-1:0] wr_data,
   input  logic [1:0]       rd_addr,
   output logic [CNT_W-1:0] rd_data,
   input  logic             tmr_in,
   output logic             tmr_out
);
   localparam int unsigned CTRL_BITS = BIT_GATE + 1;

   generate
      if (CNT_W < CTRL_BITS) begin : g_bad_w
         $error("dual_cmp_timer: CNT_W too narrow for control bits");
      end
   endgenerate

   logic             tick, run, loop_md, dual_md, gate_md, start, seq_done, active;
   logic [CNT_W-1:0] lim_a, lim_b, count, ctrl_rd;

   tmr_tick #(.DIV(TICK_DIV)) u_tick (
      .clk(clk), .rst_n(rst_n), .tick(tick));

   tmr_regs #(.CNT_W(CNT_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .seq_done(seq_done), .run(run), .loop_md(loop_md),
      .dual_md(dual_md), .gate_md(gate_md), .start(start),
      .lim_a(lim_a), .lim_b(lim_b));

   assign active = run && (!gate_md || tmr_in);

   tmr_core #(.CNT_W(CNT_W)) u_core (
      .clk(clk), .rst_n(rst_n), .tick(tick), .active(active),
      .loop_md(loop_md), .dual_md(dual_md), .start(start),
      .cnt_wr(wr_en && (wr_addr == ADDR_COUNT)), .cnt_wdata(wr_data),
      .lim_a(lim_a), .lim_b(lim_b), .count(count), .pin_out(tmr_out),
      .seq_done(seq_done));

   always_comb begin
      ctrl_rd           = '0;
      ctrl_rd[BIT_RUN]  = run;
      ctrl_rd[BIT_LOOP] = loop_md;
      ctrl_rd[BIT_DUAL] = dual_md;
      ctrl_rd[BIT_GATE] = gate_md;
   end

   always_comb begin
      case (rd_addr)
         ADDR_COUNT: rd_data = count;
         ADDR_LIM_A: rd_data = lim_a;
         ADDR_LIM_B: rd_data = lim_b;
         default:    rd_data = ctrl_rd;
      endcase
   end
endmodule

// File: tb/dual_cmp_timer_tb.sv
module dual_cmp_timer_tb;
   localparam logic [15:0] RUN = 16'h1, KEY = 16'h2, LOOP = 16'h4, DUAL = 16'h8, GATE = 16'h10;
   localparam int NV = 7;
   // each entry: limit A, clocks waited after start, expected count
   localparam int VEC [NV][3] = '{
      '{5, 12, 3}, '{5, 20, 0}, '{5, 28, 2}, '{7, 40, 3},
      '{0, 40, 10}, '{1, 8, 0}, '{3, 24, 0}};

   logic        clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, tmr_in = 1'b0;
   logic [1:0]  wr_addr = '0, rd_addr = '0;
   logic [15:0] wr_data = '0, rd_data;
   logic        tmr_out;
   int          errors = 0, checks = 0;
   bit          done = 1'b0;

   dual_cmp_timer u_dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .tmr_in(tmr_in), .tmr_out(tmr_out));

   always #4 clk = ~clk;

   task automatic chk(input string tag, input int got, input int exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [15:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output int v);
      rd_addr = a;
      #1 v = rd_data;
   endtask

   task automatic count_level(input int n, input logic lvl, output int hits);
      hits = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (tmr_out == lvl) hits++;
      end
   endtask

   task automatic restart(input logic [15:0] mode);
      wr(2'd3, KEY);
      wr(2'd3, KEY | RUN | mode);
   endtask

   initial begin
      #1_200_000;
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      int v, n;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R13 reset state
      rd(2'd0, v); chk("R13 count", v, 0);
      rd(2'd3, v); chk("R13 ctrl", v, 0);
      chk("R13 out", int'(tmr_out), 1);
      // R5 run write without key is ignored
      wr(2'd1, 16'd5);
      wr(2'd3, RUN | LOOP);
      rd(2'd3, v); chk("R5 ctrl no key", v, 4);
      repeat (40) @(negedge clk);
      rd(2'd0, v); chk("R5 count idle", v, 0);
      // table: R8 wrap, R9 service rate, R10 zero limit
      for (int k = 0; k < NV; k++) begin
         wr(2'd1, 16'(VEC[k][0]));
         restart(LOOP);
         repeat (VEC[k][1]) @(negedge clk);
         rd(2'd0, v); chk($sformatf("R8/R9/R10 vec%0d", k), v, VEC[k][2]);
      end
      // R4 frozen when disabled
      wr(2'd3, KEY | LOOP);
      rd(2'd0, n);
      repeat (40) @(negedge clk);
      rd(2'd0, v); chk("R4 hold", v, n);
      // R12 start clears count
      wr(2'd0, 16'd7);
      rd(2'd0, v); chk("R12 preload", v, 7);
      wr(2'd3, KEY | RUN | LOOP);
      rd(2'd0, v); chk("R12 cleared", v, 0);
      // R10 full range
      wr(2'd1, 16'd0);
      restart(LOOP);
      wr(2'd0, 16'hFFFD);
      repeat (16) @(negedge clk);
      rd(2'd0, v); chk("R10 wrap past FFFF", v, 1);
      // R11 single looping pulse
      wr(2'd1, 16'd5);
      restart(LOOP);
      repeat (20) @(negedge clk);
      count_level(200, 1'b0, n); chk("R11 low clocks", n, 40);
      // R7 single non-looping
      restart(16'h0);
      count_level(100, 1'b0, n); chk("R11 single pulse", n, 4);
      rd(2'd3, v); chk("R7 single run cleared", v & 1, 0);
      rd(2'd0, v); chk("R8 back to zero", v, 0);
      // R1 / R3 dual looping
      wr(2'd1, 16'd10);
      wr(2'd2, 16'd20);
      restart(LOOP | DUAL);
      chk("R1 phase A high", int'(tmr_out), 1);
      repeat (44) @(negedge clk);
      chk("R1 phase B low", int'(tmr_out), 0);
      rd(2'd0, v); chk("R1 count in B", v, 1);
      repeat (100) @(negedge clk);
      count_level(240, 1'b1, n); chk("R3 duty high", n, 80);
      // R7 / R2 dual non-looping
      wr(2'd1, 16'd3);
      wr(2'd2, 16'd2);
      restart(DUAL);
      count_level(60, 1'b0, n); chk("R2 low clocks", n, 8);
      chk("R2 ends high", int'(tmr_out), 1);
      rd(2'd3, v); chk("R7 dual run cleared", v & 1, 0);
      // R6 gate pin
      wr(2'd1, 16'd100);
      tmr_in = 1'b0;
      restart(LOOP | GATE);
      repeat (40) @(negedge clk);
      rd(2'd0, v); chk("R6 gate closed", v, 0);
      tmr_in = 1'b1;
      repeat (40) @(negedge clk);
      rd(2'd0, v); chk("R6 gate open", v, 10);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule